// File: doc/BRIEF.md
# RAM ECC Write Error Injector

This block sits between the ECC encoder and the array of a SEC-DED protected RAM. It lets software corrupt stored codewords on purpose, so that the read-side correction and error-reporting paths can be tested. Every codeword on its way to the RAM leaves the block with the selected bits inverted, or with no change at all. The inversion is combinational, so the RAM write timing does not change.

A configuration write carries the ID of the bus master that issues it. It sets a 7-bit bit position, a protection bit and three injection controls:

- **Continuous single-bit:** inverts the selected bit on every write.
- **Single-shot single-bit:** inverts the selected bit on the first write only.
- **Continuous non-correctable:** inverts the selected bit together with the overall parity bit, at position 71.

The single-shot control is sequenced by a small state machine with three states:

- **IDLE:** nothing is armed. The **ARM** transition (a permitted write that sets a control which is stored as 0) leads to ARMED.
- **ARMED:** the next write is corrupted. The **FIRE** transition (any RAM write strobe) leads to SPENT. The **CLEAR** transition (a permitted write of 0) leads back to IDLE.
- **SPENT:** the shot has been used. The **RELEASE** transition (a permitted write of 0) leads to IDLE.

Top module: `ecc_err_injector`

## Requirements
- R1: After reset, all three injection controls and the protection bit are 0, and a RAM write passes its codeword through unchanged.
- R2: While the continuous single-bit control is 1, every RAM write has codeword bit `bitpos` inverted, and no other bit is inverted.
- R3: After the single-shot control goes from 0 to 1, only the first RAM write has bit `bitpos` inverted. Later writes pass unchanged.
- R4: Writing 1 again to a single-shot control that is already 1 does not re-arm it. Writing 0 and then 1 does re-arm it.
- R5: While the non-correctable control is 1, every RAM write has bit `bitpos` and bit 71 inverted.
- R6: When the non-correctable control and a single-bit control are active together, the non-correctable pattern is applied. A write made under this condition still uses up an armed single shot.
- R7: When `bitpos` is 72 or more, no bit is inverted in any mode.
- R8: While the stored protection bit is 1, a configuration write from a master ID other than 0 leaves the three injection controls unchanged, but still updates `bitpos` and the protection bit. A write from master 0 updates all fields.
- R9: While the stored protection bit is 0, a configuration write from any master updates the injection controls.
- R10: When `wr_en` is 0, `cw_out` equals `cw_in`. When `wr_en` is 1, the corruption appears in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_id | input | 4 | Master ID of the configuration write |
| cfg_prot | input | 1 | New protection bit (1 = only master 0 may set controls) |
| cfg_cont1 | input | 1 | New continuous single-bit control |
| cfg_one1 | input | 1 | New single-shot single-bit control |
| cfg_nc | input | 1 | New continuous non-correctable control |
| cfg_bitpos | input | 7 | New bit position to corrupt |
| wr_en | input | 1 | RAM write strobe |
| cw_in | input | 72 | Codeword from the encoder (check bits in 64..71, overall parity at 71) |
| cw_out | output | 72 | Codeword to the RAM, with the selected bits inverted |

## Verification
A single-shot machine stuck in ARMED shows up at the very next RAM write, as an inverted bit on a write that should have passed unchanged. A machine that misses the ARM transition shows up on the first write after the control is set, as a missing inversion. A wrong protection decision appears at the first write after the configuration write: injection is still present when it should have been cleared, or absent when it should have been set. Every state fault is therefore visible within one RAM write, because `cw_out` is compared with `cw_in` bit by bit in the cycle of each strobe.

// File: rtl/eij_pkg.sv
package eij_pkg;
    typedef enum logic [1:0] {
        SHOT_IDLE  = 2'd0,
        SHOT_ARMED = 2'd1,
        SHOT_SPENT = 2'd2
    } shot_state_e;

    typedef struct packed {
        logic prot;
        logic cont1;
        logic one1;
        logic nc;
    } ctl_t;
endpackage

// File: rtl/eij_ctl_regs.sv
module eij_ctl_regs
    import eij_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int POS_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [ID_W-1:0]  cfg_id,
    input  ctl_t             cfg_new,
    input  logic [POS_W-1:0] cfg_bitpos,
    output ctl_t             ctl_q,
    output logic [POS_W-1:0] bitpos_q,
    output logic             ctl_wr
);
    // Controls may change only if protection is off or the writer is master 0
    assign ctl_wr = cfg_we && (!ctl_q.prot || (cfg_id == '0));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            bitpos_q <= '0;
        end else begin
            if (cfg_we) begin
                ctl_q.prot <= cfg_new.prot;
                bitpos_q   <= cfg_bitpos;
            end
            if (ctl_wr) begin
                ctl_q.cont1 <= cfg_new.cont1;
                ctl_q.one1  <= cfg_new.one1;
                ctl_q.nc    <= cfg_new.nc;
            end
        end
    end
endmodule

// File: rtl/eij_shot_fsm.sv
module eij_shot_fsm
    import eij_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_wr,
    input  logic        one1_new,
    input  logic        one1_q,
    input  logic        wr_en,
    output shot_state_e state_q,
    output logic        shot_live
);
    shot_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SHOT_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SHOT_IDLE:  if (ctl_wr && one1_new && !one1_q) state_d = SHOT_ARMED; // ARM
            SHOT_ARMED: if (ctl_wr && !one1_new)           state_d = SHOT_IDLE;  // CLEAR
                        else if (wr_en)                    state_d = SHOT_SPENT; // FIRE
            SHOT_SPENT: if (ctl_wr && !one1_new)           state_d = SHOT_IDLE;  // RELEASE
            default:                                       state_d = SHOT_IDLE;
        endcase
    end

    always_comb begin
        shot_live = (state_q == SHOT_ARMED);
    end
endmodule

// File: rtl/eij_flip_mask.sv
module eij_flip_mask #(
    parameter int CW_W  = 72,
    parameter int POS_W = 7
) (
    input  logic             wr_en,
    input  logic [POS_W-1:0] bitpos,
    input  logic             sel_single,
    input  logic             sel_nc,
    output logic [CW_W-1:0]  mask
);
    localparam int PAR_POS = CW_W - 1;

    logic in_range;
    logic any_sel;
    assign in_range = (32'(bitpos) < CW_W);
    assign any_sel  = wr_en && in_range && (sel_single || sel_nc);

    for (genvar i = 0; i < CW_W; i++) begin : g_bit
        if (i == PAR_POS) begin : g_par
            assign mask[i] = (any_sel && (32'(bitpos) == i)) ||
                             (wr_en && in_range && sel_nc);
        end else begin : g_data
            assign mask[i] = any_sel && (32'(bitpos) == i);
        end
    end
endmodule

// File: rtl/ecc_err_injector.sv
module ecc_err_injector
    import eij_pkg::*;
#(
    parameter int CW_W  = 72,
    parameter int POS_W = 7,
    parameter int ID_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [ID_W-1:0]  cfg_id,
    input  logic             cfg_prot,
    input  logic             cfg_cont1,
    input  logic             cfg_one1,
    input  logic             cfg_nc,
    input  logic [POS_W-1:0] cfg_bitpos,
    input  logic             wr_en,
    input  logic [CW_W-1:0]  cw_in,
    output logic [CW_W-1:0]  cw_out
);
    ctl_t             cfg_new;
    ctl_t             ctl_q;
    logic [POS_W-1:0] bitpos_q;
    logic             ctl_wr;
    shot_state_e      shot_state;
    logic             shot_live;
    logic [CW_W-1:0]  mask;

    assign cfg_new = '{prot: cfg_prot, cont1: cfg_cont1, one1: cfg_one1, nc: cfg_nc};

    eij_ctl_regs #(.ID_W(ID_W), .POS_W(POS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_new(cfg_new), .cfg_bitpos(cfg_bitpos),
        .ctl_q(ctl_q), .bitpos_q(bitpos_q), .ctl_wr(ctl_wr)
    );

    eij_shot_fsm u_shot (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .one1_new(cfg_one1),
        .one1_q(ctl_q.one1), .wr_en(wr_en),
        .state_q(shot_state), .shot_live(shot_live)
    );

    eij_flip_mask #(.CW_W(CW_W), .POS_W(POS_W)) u_mask (
        .wr_en(wr_en), .bitpos(bitpos_q),
        .sel_single(ctl_q.cont1 || shot_live), .sel_nc(ctl_q.nc),
        .mask(mask)
    );

    assign cw_out = cw_in ^ mask;
endmodule

// File: rtl/eij_checker.sv
module eij_checker
    import eij_pkg::*;
#(
    parameter int CW_W  = 72,
    parameter int POS_W = 7,
    parameter int ID_W  = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [ID_W-1:0]  cfg_id,
    input logic             wr_en,
    input logic [CW_W-1:0]  cw_in,
    input logic [CW_W-1:0]  cw_out,
    input ctl_t             ctl_q,
    input logic [POS_W-1:0] bitpos_q,
    input shot_state_e      shot_state
);
    localparam int PAR_POS = CW_W - 1;

    assert_pass_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> (cw_out == cw_in));

    assert_max_two_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cw_out ^ cw_in) <= 2);

    assert_nc_pattern_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_q.nc && (32'(bitpos_q) < PAR_POS)) |->
            ((cw_out[PAR_POS] != cw_in[PAR_POS]) && ($countones(cw_out ^ cw_in) == 2)));

    assert_out_of_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(bitpos_q) >= CW_W) |-> (cw_out == cw_in));

    assert_fire_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (shot_state == SHOT_ARMED && !wr_en && !cfg_we) |=> (shot_state == SHOT_ARMED));

    assert_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && ctl_q.prot && (cfg_id != '0)) |=>
            ({ctl_q.cont1, ctl_q.one1, ctl_q.nc} == $past({ctl_q.cont1, ctl_q.one1, ctl_q.nc})));
endmodule

bind ecc_err_injector eij_checker #(.CW_W(CW_W), .POS_W(POS_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id), .wr_en(wr_en),
    .cw_in(cw_in), .cw_out(cw_out), .ctl_q(ctl_q), .bitpos_q(bitpos_q),
    .shot_state(shot_state)
);

// File: tb/sim_ecc_err_injector.sv
module sim_ecc_err_injector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_id = '0;
    logic        cfg_prot = 1'b0, cfg_cont1 = 1'b0, cfg_one1 = 1'b0, cfg_nc = 1'b0;
    logic [6:0]  cfg_bitpos = '0;
    logic        wr_en = 1'b0;
    logic [71:0] cw_in = '0;
    logic [71:0] cw_out;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    localparam logic [71:0] PAT_A = 72'hA5_0123_4567_89AB_CDEF;
    localparam logic [71:0] PAT_B = 72'h3C_FEDC_BA98_7654_3210;

    always #10 clk = ~clk;

    ecc_err_injector u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_prot(cfg_prot), .cfg_cont1(cfg_cont1), .cfg_one1(cfg_one1),
        .cfg_nc(cfg_nc), .cfg_bitpos(cfg_bitpos), .wr_en(wr_en),
        .cw_in(cw_in), .cw_out(cw_out)
    );

    function automatic logic [71:0] bits2(int a, int b);
        logic [71:0] m = '0;
        if (a >= 0 && a < 72) m[a] = 1'b1;
        if (b >= 0 && b < 72) m[b] = 1'b1;
        return m;
    endfunction

    task automatic cfg(input int id, input bit p, input bit c1, input bit o1,
                       input bit nc, input int pos);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = 4'(id); cfg_prot = p; cfg_cont1 = c1;
        cfg_one1 = o1; cfg_nc = nc; cfg_bitpos = 7'(pos);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic ram_wr(input logic [71:0] v, input logic [71:0] m, input string tag);
        @(negedge clk);
        wr_en = 1'b1; cw_in = v;
        #2;
        checks++;
        if (cw_out !== (v ^ m)) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, cw_out, v ^ m);
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        ram_wr(PAT_A, '0, "R1 reset passthrough");
    endtask

    task automatic t_idle_pass();
        cfg(0, 0, 1, 0, 0, 9);
        @(negedge clk);
        wr_en = 1'b0; cw_in = PAT_B;
        #2;
        checks++;
        if (cw_out !== PAT_B) begin
            errors++;
            $display("FAIL R10 no strobe: got %h expected %h", cw_out, PAT_B);
        end
        ram_wr(PAT_B, bits2(9, -1), "R10 same-cycle flip");
        cfg(0, 0, 0, 0, 0, 9);
    endtask

    task automatic t_cont1();
        cfg(0, 0, 1, 0, 0, 5);
        ram_wr(PAT_A, bits2(5, -1), "R2 first write");
        ram_wr(PAT_B, bits2(5, -1), "R2 second write");
        cfg(0, 0, 0, 0, 0, 5);
        ram_wr(PAT_A, '0, "R2 after clear");
    endtask

    task automatic t_single();
        cfg(0, 0, 0, 1, 0, 10);
        ram_wr(PAT_A, bits2(10, -1), "R3 first write");
        ram_wr(PAT_B, '0, "R3 second write");
        ram_wr(PAT_A, '0, "R3 third write");
    endtask

    task automatic t_rearm();
        cfg(0, 0, 0, 1, 0, 10);
        ram_wr(PAT_A, '0, "R4 rewrite 1 no rearm");
        cfg(0, 0, 0, 0, 0, 10);
        cfg(0, 0, 0, 1, 0, 64);
        ram_wr(PAT_B, bits2(64, -1), "R4 clear then set rearms");
        ram_wr(PAT_B, '0, "R4 rearmed shot spent");
        cfg(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_nc();
        cfg(0, 0, 0, 0, 1, 3);
        ram_wr(PAT_A, bits2(3, 71), "R5 first write");
        ram_wr(PAT_B, bits2(3, 71), "R5 second write");
        cfg(0, 0, 0, 0, 0, 3);
    endtask

    task automatic t_prio();
        cfg(0, 0, 1, 0, 1, 7);
        ram_wr(PAT_A, bits2(7, 71), "R6 nc over continuous");
        cfg(0, 0, 0, 0, 0, 7);
        cfg(0, 0, 0, 1, 1, 7);
        ram_wr(PAT_B, bits2(7, 71), "R6 nc over single");
        cfg(0, 0, 0, 1, 0, 7);
        ram_wr(PAT_B, '0, "R6 shot consumed under nc");
        cfg(0, 0, 0, 0, 0, 7);
    endtask

    task automatic t_range();
        cfg(0, 0, 1, 0, 0, 72);
        ram_wr(PAT_A, '0, "R7 pos 72 continuous");
        cfg(0, 0, 1, 0, 0, 127);
        ram_wr(PAT_B, '0, "R7 pos 127 continuous");
        cfg(0, 0, 0, 0, 1, 100);
        ram_wr(PAT_A, '0, "R7 pos 100 nc");
        cfg(0, 0, 0, 0, 0, 0);
    endtask

    task automatic t_prot();
        cfg(0, 1, 1, 0, 0, 20);
        ram_wr(PAT_A, bits2(20, -1), "R8 master 0 sets");
        cfg(3, 1, 0, 0, 0, 30);
        ram_wr(PAT_A, bits2(30, -1), "R8 blocked ctl, pos updated");
        cfg(3, 0, 0, 0, 0, 30);
        ram_wr(PAT_B, bits2(30, -1), "R8 blocked ctl, prot updated");
        cfg(3, 0, 0, 0, 0, 30);
        ram_wr(PAT_B, '0, "R9 open master clears");
        cfg(5, 0, 0, 0, 1, 2);
        ram_wr(PAT_A, bits2(2, 71), "R9 open master sets");
        cfg(5, 0, 0, 0, 0, 2);
    endtask

    initial begin
        #200000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_idle_pass();
        t_cont1();
        t_single();
        t_rearm();
        t_nc();
        t_prio();
        t_range();
        t_prot();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule